// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a byte-addressed serial memory with an I2C slave interface, for use where a serial EEPROM would otherwise sit on the board bus. It runs entirely in a fast system clock domain. SCL and SDA are oversampled and synchronised there. From the sampled lines the block detects START and STOP conditions and the edges of SCL. It then walks each transfer through device select, address and data phases. SDA is handled as an open-drain line: the block only asserts an output enable that pulls the line low, and it never drives it high.

A transfer opens with a device select byte. It can go on to a write with a two-byte address and any number of data bytes. It can also be a read: from the current pointer, from a fresh address through a repeated START, or a stream of bytes paced by the master's acknowledges. An internal pointer advances after each byte and wraps at the top of the array. Two strap inputs choose the slave address. A write-control input blocks every write. A power-good input holds the whole block in reset. The array depth is a parameter: the full part uses 15 address bits, and the default build keeps the storage small.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: While `rst` is high or `pwr_good` is low, `sda_oe` stays 0 and the block acknowledges nothing, including its own select byte.
- R2: A select byte is acknowledged only when bits 7..4 equal 1010, bit 3 is 0 and bits 2..1 equal `chip_en[1:0]`. Any other select byte gets no acknowledge, and the rest of that transfer is ignored.
- R3: Each byte the master writes to a matching device is acknowledged by `sda_oe` being 1 during the ninth SCL high period: the select byte, both address bytes, and data bytes while writes are enabled.
- R4: After a write select (bit 0 = 0), two address bytes follow, high byte first. Of the 15-bit address, only the low ADDR_W bits select a location. Each following data byte is stored at the pointer, and the pointer then advances by one.
- R5: With `wr_ctrl` high, both address bytes are still acknowledged, but a data byte gets no acknowledge and memory keeps its contents.
- R6: A write select plus two address bytes, followed by a repeated START and a read select (bit 0 = 1), returns the byte stored at that address.
- R7: In a read, each master acknowledge causes the next byte, from pointer + 1, to be sent. A master no-acknowledge ends the read.
- R8: A read select with no address phase returns the byte at the current pointer, which is one past the last byte read or written.
- R9: `sda_oe` changes only while SCL is low. Every rise of `sda_oe` follows a falling SCL edge, so the block never disturbs SDA during an SCL high period.
- R10: The pointer wraps from the highest location (2^ADDR_W - 1) to location 0, for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply valid; low holds the block in reset |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_en | input | 2 | Strap values expected in select bits 2..1 |
| wr_ctrl | input | 1 | 1 blocks all writes to the array |

## Verification
On every cycle, assertions check four things: the block stays silent while power is absent; `sda_oe` rises only after a falling SCL edge; a select acknowledge is held only for a byte that matches the type code, the zero bit and the straps; and a memory write only happens while writes are enabled. Only the bench scenarios can show that data lands at the right address and comes back in the right order. That covers the random, current-address and sequential reads, the wrap at the top of the array, the ignoring of the upper address bits, and the protected write leaving memory unchanged.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_RACK
  } phase_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev, scl_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr   <= '1;
      sda_sr   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sr   <= {scl_sr[SYNC_STAGES-2:0], scl_in};
      sda_sr   <= {sda_sr[SYNC_STAGES-2:0], sda_in};
      scl_prev <= scl_sr[SYNC_STAGES-1];
      sda_prev <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_now   = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/eeprom_proto_fsm.sv
module eeprom_proto_fsm
  import eeprom_slave_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [1:0]    chip_en,
  input  logic          wr_ctrl,
  input  logic [7:0]    rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          sda_oe
);
  localparam int HI_W = AW - 8;

  phase_t          ph, nxt_ph;
  logic [3:0]      cnt;
  logic [7:0]      shreg, txreg;
  logic [HI_W-1:0] addr_hi;
  logic [AW-1:0]   ptr;
  logic            in_ack, oe_q, we_q;
  logic            sel_match;

  assign sel_match = (shreg[7:4] == TYPE_CODE) && !shreg[3] && (shreg[2:1] == chip_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      nxt_ph  <= PH_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      txreg   <= '0;
      addr_hi <= '0;
      ptr     <= '0;
      in_ack  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr <= ptr + 1'b1;
      if (start_det) begin
        ph     <= PH_SEL;
        cnt    <= '0;
        in_ack <= 1'b0;
        oe_q   <= 1'b0;
      end else if (stop_det) begin
        ph     <= PH_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        oe_q   <= 1'b0;
      end else begin
        case (ph)
          PH_SEL, PH_AHI, PH_ALO, PH_WDAT: begin
            if (scl_rise && !in_ack && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              oe_q   <= 1'b0;
              cnt    <= '0;
              ph     <= nxt_ph;
              if (nxt_ph == PH_RDAT) begin
                txreg <= rdata;
                oe_q  <= ~rdata[7];
                ptr   <= ptr + 1'b1;
              end
            end else if (scl_fall && cnt == 4'd8) begin
              case (ph)
                PH_SEL: begin
                  if (sel_match) begin
                    in_ack <= 1'b1;
                    oe_q   <= 1'b1;
                    nxt_ph <= shreg[0] ? PH_RDAT : PH_AHI;
                  end else begin
                    ph <= PH_IDLE;
                  end
                end
                PH_AHI: begin
                  in_ack  <= 1'b1;
                  oe_q    <= 1'b1;
                  addr_hi <= shreg[HI_W-1:0];
                  nxt_ph  <= PH_ALO;
                end
                PH_ALO: begin
                  in_ack <= 1'b1;
                  oe_q   <= 1'b1;
                  ptr    <= {addr_hi, shreg};
                  nxt_ph <= PH_WDAT;
                end
                default: begin
                  if (!wr_ctrl) begin
                    in_ack <= 1'b1;
                    oe_q   <= 1'b1;
                    we_q   <= 1'b1;
                    nxt_ph <= PH_WDAT;
                  end else begin
                    ph <= PH_IDLE;
                  end
                end
              endcase
            end
          end
          PH_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe_q <= 1'b0;
                cnt  <= '0;
                ph   <= PH_RACK;
              end else if (cnt != 4'd0) begin
                oe_q <= ~txreg[3'd7 - cnt[2:0]];
              end
            end
          end
          PH_RACK: begin
            if (scl_rise) begin
              if (sda_s) ph <= PH_IDLE;
              else in_ack <= 1'b1;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              txreg  <= rdata;
              oe_q   <= ~rdata[7];
              ptr    <= ptr + 1'b1;
              cnt    <= '0;
              ph     <= PH_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = ptr;
  assign mem_wdata = shreg;
  assign sda_oe    = oe_q;

  // R9: the pull-down is only applied after the sampler has seen SCL fall
  a_r9_oe_rises_after_scl_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(scl_fall));

  // R2: an acknowledge held for a select byte requires a full address match
  a_r2_select_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SEL && in_ack) |-> (shreg[7:4] == 4'b1010 && !shreg[3] && shreg[2:1] == chip_en));

  // R5: a memory write only follows a sample with writes enabled
  a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !$past(wr_ctrl));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [1:0] chip_en,
  input  logic       wr_ctrl
);
  logic              core_rst;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  assign core_rst = rst | ~pwr_good;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst       (core_rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eeprom_proto_fsm #(.AW(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst       (core_rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .chip_en   (chip_en),
    .wr_ctrl   (wr_ctrl),
    .rdata     (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe)
  );

  eeprom_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  // R1: losing power silences the bus output from the next cycle on
  a_r1_silent_without_power: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> !sda_oe);
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int AW   = 11;
  localparam int Q    = 8;
  localparam int TOPA = (1 << AW) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       wr_ctrl = 1'b0;
  logic [1:0] chip_en = 2'b10;
  logic       sda_oe;
  logic       sda_line;
  logic       oe_prev = 1'b0;
  int         checks = 0;
  int         errors = 0;
  int         oe_hi_changes = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(AW)) u_i2c_eeprom_slave (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .chip_en  (chip_en),
    .wr_ctrl  (wr_ctrl)
  );

  // R9 monitor: the pull-down must stay put while SCL is high
  always @(negedge clk) begin
    if (scl && (sda_oe !== oe_prev)) oe_hi_changes++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sel(input logic [1:0] ce, input bit rw);
    return {4'b1010, 1'b0, ce, rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl = 1'b0; waitc(2);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; waitc(Q);
    scl = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl = 1'b0; waitc(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(Q);
      scl = 1'b1; waitc(Q);
      scl = 1'b0; waitc(2);
    end
    sda_m = 1'b1; waitc(Q);
    scl = 1'b1; waitc(Q / 2);
    ack = !sda_line;
    waitc(Q / 2);
    scl = 1'b0; waitc(2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitc(Q);
      scl = 1'b1; waitc(Q / 2);
      d = {d[6:0], sda_line};
      waitc(Q / 2);
      scl = 1'b0; waitc(2);
    end
    sda_m = mack ? 1'b0 : 1'b1; waitc(Q);
    scl = 1'b1; waitc(Q);
    scl = 1'b0; waitc(2);
    sda_m = 1'b1;
  endtask

  task automatic set_address(input logic [14:0] a, input string req);
    bit ack;
    bus_start();
    send_byte(sel(chip_en, 1'b0), ack);
    check(ack, {req, " select ack"}, ack, 1);
    send_byte({1'b0, a[14:8]}, ack);
    check(ack, {req, " high address ack"}, ack, 1);
    send_byte(a[7:0], ack);
    check(ack, {req, " low address ack"}, ack, 1);
  endtask

  task automatic t_reset();
    waitc(3);
    check(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    waitc(5);
    check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
  endtask

  // R3 R4: upper address bits are dropped, three bytes land in order
  task automatic t_random_write();
    bit ack;
    set_address(15'h4123, "R3");
    send_byte(8'h11, ack); check(ack, "R3 data ack 0", ack, 1);
    send_byte(8'h22, ack); check(ack, "R3 data ack 1", ack, 1);
    send_byte(8'h33, ack); check(ack, "R3 data ack 2", ack, 1);
    bus_stop();
  endtask

  task automatic t_random_read();
    bit ack;
    logic [7:0] d;
    set_address(15'h0124, "R6");
    bus_rstart();
    send_byte(sel(chip_en, 1'b1), ack);
    check(ack, "R6 read select ack", ack, 1);
    recv_byte(1'b0, d);
    check(d == 8'h22, "R6 R4 random read", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_current_read();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(sel(chip_en, 1'b1), ack);
    check(ack, "R8 select ack", ack, 1);
    recv_byte(1'b0, d);
    check(d == 8'h33, "R8 current address read", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_seq_read();
    bit ack;
    logic [7:0] d0, d1, d2;
    set_address(15'h0123, "R7");
    bus_rstart();
    send_byte(sel(chip_en, 1'b1), ack);
    recv_byte(1'b1, d0);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    check(d0 == 8'h11, "R7 R4 seq byte 0", d0, 8'h11);
    check(d1 == 8'h22, "R7 R4 seq byte 1", d1, 8'h22);
    check(d2 == 8'h33, "R7 R4 seq byte 2", d2, 8'h33);
    check(sda_oe == 1'b0, "R7 released after no-ack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_bad_select();
    bit ack;
    bus_start();
    send_byte(8'b1011_0100, ack);
    check(!ack, "R2 wrong type code", ack, 0);
    bus_stop();
    bus_start();
    send_byte(sel(~chip_en, 1'b0), ack);
    check(!ack, "R2 wrong strap bits", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 rest of transfer ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1010, 1'b1, chip_en, 1'b0}, ack);
    check(!ack, "R2 bit 3 set", ack, 0);
    bus_stop();
  endtask

  task automatic t_write_protect();
    bit ack;
    logic [7:0] d;
    wr_ctrl = 1'b1;
    set_address(15'h0123, "R5");
    send_byte(8'h99, ack);
    check(!ack, "R5 protected data no-ack", ack, 0);
    bus_stop();
    wr_ctrl = 1'b0;
    set_address(15'h0123, "R5");
    bus_rstart();
    send_byte(sel(chip_en, 1'b1), ack);
    recv_byte(1'b0, d);
    check(d == 8'h11, "R5 memory unchanged", d, 8'h11);
    bus_stop();
  endtask

  task automatic t_power_loss();
    bit ack;
    pwr_good = 1'b0;
    waitc(4);
    bus_start();
    send_byte(sel(chip_en, 1'b0), ack);
    check(!ack, "R1 no ack without power", ack, 0);
    check(sda_oe == 1'b0, "R1 oe low without power", sda_oe, 0);
    bus_stop();
    pwr_good = 1'b1;
    waitc(4);
  endtask

  task automatic t_wrap();
    bit ack;
    logic [7:0] d0, d1;
    set_address(15'(TOPA), "R10");
    send_byte(8'hA5, ack);
    send_byte(8'h5A, ack);
    check(ack, "R10 wrapped write ack", ack, 1);
    bus_stop();
    set_address(15'(TOPA), "R10");
    bus_rstart();
    send_byte(sel(chip_en, 1'b1), ack);
    recv_byte(1'b1, d0);
    recv_byte(1'b0, d1);
    check(d0 == 8'hA5, "R10 top location", d0, 8'hA5);
    check(d1 == 8'h5A, "R10 read wraps to 0", d1, 8'h5A);
    bus_stop();
    set_address(15'h0000, "R10");
    bus_rstart();
    send_byte(sel(chip_en, 1'b1), ack);
    recv_byte(1'b0, d0);
    check(d0 == 8'h5A, "R10 write wrapped to 0", d0, 8'h5A);
    bus_stop();
  endtask

  initial begin
    t_reset();
    t_random_write();
    t_random_read();
    t_current_read();
    t_seq_read();
    t_bad_select();
    t_write_protect();
    t_power_loss();
    t_wrap();
    check(oe_hi_changes == 0, "R9 oe stable while SCL high", oe_hi_changes, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitc(150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule